// File: doc/BRIEF.md
# C/I Channel Transmit Controller

This block sends a short command/indication (C/I) code from a CPU to a framed serial line, for several ports at once, and reports back when the far end has had time to see the code. For each port, software writes a byte that holds the code and a ready flag. Setting the ready flag from 0 to 1 starts that port's sequencer. On each frame strobe, the sequencer drives the code into the port's C/I slot. After the same code has gone out in a set number of back-to-back frames (two by default), the sequencer clears the ready flag itself, sets the port's bit in a sticky status word and may raise an interrupt.

Serialization of the frame is done outside this block. The block only presents a per-port code and a one-cycle valid flag after each frame strobe. Between transmissions, a port's slot keeps showing the last code that completed, so the remote side sees a steady value. A single-cycle software reset has the same effect as the hardware reset.

Top module: `ci_tx_ctrl`

## Requirements
- R1: After hardware reset, all three registers read zero, `ci_code` and `ci_valid` are zero and `irq` is low.
- R2: At register select 0, port p owns byte lane NUM_PORTS-1-p (port 0 in bits 31:24, port 3 in bits 7:0). `reg_be` bit b enables lane b (bits 8b+7:8b). Within a port byte, bits 3:0 are the code and bit 4 is the ready flag. Bits 7:5 ignore writes and read zero.
- R3: A port starts only when its ready flag goes from 0 to 1. Rewriting the byte with the ready flag still 1 and the same code does not restart the frame count.
- R4: In the cycle after a `frame_sync` pulse, each active port p drives `ci_valid[p]`=1 for one cycle and drives its code on `ci_code[4p+3:4p]`.
- R5: A port's status bit (select 1, bit p) is set after the second consecutive frame that carries its code, and not after the first.
- R6: When the status bit is set, the port's ready flag reads 0 and its code bits are kept.
- R7: An idle port raises no valid on `frame_sync`. On each `frame_sync` its `ci_code` slot shows the last code that completed, or zero if none has completed.
- R8: Writing a different code while a port is active restarts its frame count, so the new code needs two more frames before it is acknowledged.
- R9: Writing the ready flag to 0 while a port is active stops the port without setting its status bit.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R11: `irq` is high exactly when some status bit is set and the matching bit of the mask register (select 2, bit p, 1 = enabled) is set.
- R12: A one-cycle `sw_rst` pulse returns all registers, sequencers and outputs to the reset state of R1.
- R13: Register select 3 reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst | input | 1 | Synchronous one-cycle software reset |
| reg_addr | input | 2 | Register select: 0 codes, 1 status, 2 mask, 3 unused |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | NUM_PORTS | Byte-lane enables for the code register |
| reg_wdata | input | 8*NUM_PORTS | Write data |
| reg_rdata | output | 8*NUM_PORTS | Read data for the selected register |
| frame_sync | input | 1 | One-cycle frame strobe |
| ci_code | output | NUM_PORTS*4 | Per-port C/I slot value |
| ci_valid | output | NUM_PORTS | Per-port slot valid, one cycle after frame_sync |
| irq | output | 1 | Masked acknowledge interrupt |

## Verification
The sequencer is exercised with several patterns, each aimed at one way a faulty design could miscount frames:
- A plain two-frame run shows whether the acknowledge comes after two frames rather than one.
- A same-value rewrite in mid-run tells level triggering apart from edge triggering.
- A code change in mid-run shows whether the frame count restarts.
- A ready-clear in mid-run shows whether the port aborts without acknowledging.
- Two ports run together to expose crossed byte lanes or crossed slots.

A scoreboard pairs every expected slot value with the valid pulses the block produces. Register reads confirm the hardware ready-clear, the status clear by writing ones, the masking and the software reset.

// File: rtl/ci_tx_pkg.sv
package ci_tx_pkg;

   localparam int LANE_W = 8;

   typedef enum logic [1:0] {
      SEL_CODE = 2'd0,
      SEL_ACK  = 2'd1,
      SEL_MASK = 2'd2,
      SEL_NONE = 2'd3
   } ci_sel_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SEND = 1'b1
   } ci_state_e;

endpackage

// File: rtl/ci_port_fsm.sv
module ci_port_fsm
   import ci_tx_pkg::*;
#(
   parameter int CODE_W        = 4,
   parameter int REPEAT_FRAMES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic              wr,
   input  logic [LANE_W-1:0] wdata,
   input  logic              frame_sync,
   output logic [LANE_W-1:0] reg_byte,
   output logic [CODE_W-1:0] ci_code,
   output logic              ci_valid,
   output logic              ack_pulse
);

   localparam int               CNT_W    = $clog2(REPEAT_FRAMES + 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(REPEAT_FRAMES - 1);

   ci_state_e         state_q;
   logic [CODE_W-1:0] code_q;
   logic [CODE_W-1:0] last_q;
   logic [CODE_W-1:0] slot_q;
   logic              rdy_q;
   logic              valid_q;
   logic [CNT_W-1:0]  cnt_q;

   logic busy;
   logic rdy_rise;
   logic code_chg;
   logic rdy_drop;
   logic send;
   logic done;
   logic unused_rsv;

   assign busy       = (state_q == ST_SEND);
   assign rdy_rise   = wr && wdata[CODE_W] && !rdy_q;
   assign code_chg   = wr && (wdata[CODE_W-1:0] != code_q);
   assign rdy_drop   = wr && !wdata[CODE_W];
   assign send       = frame_sync && busy;
   assign done       = send && (cnt_q == LAST_CNT) && !code_chg && !rdy_drop;
   assign unused_rsv = ^wdata[LANE_W-1:CODE_W+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         code_q  <= '0;
         last_q  <= '0;
         slot_q  <= '0;
         rdy_q   <= 1'b0;
         valid_q <= 1'b0;
         cnt_q   <= '0;
      end else if (sw_rst) begin
         state_q <= ST_IDLE;
         code_q  <= '0;
         last_q  <= '0;
         slot_q  <= '0;
         rdy_q   <= 1'b0;
         valid_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         valid_q <= send;
         if (frame_sync) begin
            slot_q <= busy ? code_q : last_q;
         end
         if (wr) begin
            code_q <= wdata[CODE_W-1:0];
            rdy_q  <= wdata[CODE_W];
         end
         if (done) begin
            rdy_q   <= 1'b0;
            state_q <= ST_IDLE;
            last_q  <= code_q;
            cnt_q   <= '0;
         end else if (rdy_rise) begin
            state_q <= ST_SEND;
            cnt_q   <= '0;
         end else if (busy) begin
            if (rdy_drop) begin
               state_q <= ST_IDLE;
               cnt_q   <= '0;
            end else if (code_chg) begin
               cnt_q <= '0;
            end else if (send) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   always_comb begin
      reg_byte             = '0;
      reg_byte[CODE_W-1:0] = code_q;
      reg_byte[CODE_W]     = rdy_q;
   end

   assign ci_code   = slot_q;
   assign ci_valid  = valid_q;
   assign ack_pulse = done;

   // R3: entering the send state needs a write that raises a low ready flag
   a_r3_start_on_edge: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      $rose(busy) |-> $past(wr && !rdy_q));

   // R6: the acknowledge leaves the port idle with its ready flag cleared
   a_r6_ready_cleared: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      ack_pulse |=> (!rdy_q && !busy));

   // R7: a frame seen while idle produces no valid
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      (frame_sync && !busy) |=> !ci_valid);

   // R9: a port is only ever active while its ready flag is high
   a_r9_busy_needs_ready: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      busy |-> rdy_q);

endmodule

// File: rtl/ci_ack_irq.sv
module ci_ack_irq #(
   parameter int NUM_PORTS      = 4,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sw_rst,
   input  logic [NUM_PORTS-1:0] ack_set,
   input  logic                 clr_wr,
   input  logic                 mask_wr,
   input  logic [NUM_PORTS-1:0] wdata,
   output logic [NUM_PORTS-1:0] ack_q,
   output logic [NUM_PORTS-1:0] mask_q,
   output logic                 irq
);

   logic [NUM_PORTS-1:0] clr_bits;
   logic [NUM_PORTS-1:0] ack_d;

   assign clr_bits = clr_wr ? wdata : '0;
   // a new acknowledge wins over a clear in the same cycle
   assign ack_d    = (ack_q & ~clr_bits) | ack_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q  <= '0;
         mask_q <= '0;
      end else if (sw_rst) begin
         ack_q  <= '0;
         mask_q <= '0;
      end else begin
         ack_q <= ack_d;
         if (mask_wr) begin
            mask_q <= wdata;
         end
      end
   end

   generate
      if (IRQ_REGISTERED) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q <= 1'b0;
            end else if (sw_rst) begin
               irq_q <= 1'b0;
            end else begin
               irq_q <= |(ack_d & mask_q);
            end
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = |(ack_q & mask_q);

         // R11: a fully masked port set cannot interrupt
         a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
            (mask_q == '0) |-> !irq);
      end
   endgenerate

   // R10: a status bit stays set unless a one was written to it
   a_r10_ack_sticky: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      1'b1 |=> ((ack_q & $past(ack_q & ~clr_bits)) == $past(ack_q & ~clr_bits)));

   // R5: every acknowledge lands in the status word
   a_r5_ack_recorded: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      (|ack_set) |=> ((ack_q & $past(ack_set)) == $past(ack_set)));

endmodule

// File: rtl/ci_tx_ctrl.sv
module ci_tx_ctrl
   import ci_tx_pkg::*;
#(
   parameter int NUM_PORTS      = 4,
   parameter int CODE_W         = 4,
   parameter int REPEAT_FRAMES  = 2,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        sw_rst,
   input  logic [1:0]                  reg_addr,
   input  logic                        reg_wr,
   input  logic [NUM_PORTS-1:0]        reg_be,
   input  logic [LANE_W*NUM_PORTS-1:0] reg_wdata,
   output logic [LANE_W*NUM_PORTS-1:0] reg_rdata,
   input  logic                        frame_sync,
   output logic [NUM_PORTS*CODE_W-1:0] ci_code,
   output logic [NUM_PORTS-1:0]        ci_valid,
   output logic                        irq
);

   localparam int REG_W = LANE_W * NUM_PORTS;

   generate
      if (NUM_PORTS < 1) begin : g_bad_ports
         $error("ci_tx_ctrl: NUM_PORTS must be at least 1");
      end
      if (CODE_W < 1 || CODE_W + 2 > LANE_W) begin : g_bad_code
         $error("ci_tx_ctrl: CODE_W must leave room for ready and a reserved bit");
      end
      if (REPEAT_FRAMES < 1) begin : g_bad_repeat
         $error("ci_tx_ctrl: REPEAT_FRAMES must be at least 1");
      end
   endgenerate

   logic [REG_W-1:0]     code_word;
   logic [NUM_PORTS-1:0] ack_set;
   logic [NUM_PORTS-1:0] ack_q;
   logic [NUM_PORTS-1:0] mask_q;
   logic                 code_wr;
   logic                 clr_wr;
   logic                 mask_wr;

   assign code_wr = reg_wr && (reg_addr == SEL_CODE);
   assign clr_wr  = reg_wr && (reg_addr == SEL_ACK);
   assign mask_wr = reg_wr && (reg_addr == SEL_MASK);

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         localparam int LANE = NUM_PORTS - 1 - p;

         ci_port_fsm #(
            .CODE_W       (CODE_W),
            .REPEAT_FRAMES(REPEAT_FRAMES)
         ) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .sw_rst    (sw_rst),
            .wr        (code_wr && reg_be[LANE]),
            .wdata     (reg_wdata[LANE*LANE_W +: LANE_W]),
            .frame_sync(frame_sync),
            .reg_byte  (code_word[LANE*LANE_W +: LANE_W]),
            .ci_code   (ci_code[p*CODE_W +: CODE_W]),
            .ci_valid  (ci_valid[p]),
            .ack_pulse (ack_set[p])
         );
      end
   endgenerate

   ci_ack_irq #(
      .NUM_PORTS     (NUM_PORTS),
      .IRQ_REGISTERED(IRQ_REGISTERED)
   ) u_ack (
      .clk    (clk),
      .rst_n  (rst_n),
      .sw_rst (sw_rst),
      .ack_set(ack_set),
      .clr_wr (clr_wr),
      .mask_wr(mask_wr),
      .wdata  (reg_wdata[NUM_PORTS-1:0]),
      .ack_q  (ack_q),
      .mask_q (mask_q),
      .irq    (irq)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         SEL_CODE: reg_rdata = code_word;
         SEL_ACK:  reg_rdata[NUM_PORTS-1:0] = ack_q;
         SEL_MASK: reg_rdata[NUM_PORTS-1:0] = mask_q;
         default:  reg_rdata = '0;
      endcase
   end

   // R4: a slot valid only follows a frame strobe
   a_r4_valid_after_frame: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      (|ci_valid) |-> $past(frame_sync));

endmodule

// File: tb/ci_tx_ctrl_bench.sv
module ci_tx_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_rst = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_be = 4'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;
   logic        frame_sync = 1'b0;
   logic [15:0] ci_code;
   logic [3:0]  ci_valid;
   logic        irq;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_q[$];

   always #2 clk = ~clk;

   ci_tx_ctrl u_ci_tx_ctrl (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_be(reg_be),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .frame_sync(frame_sync), .ci_code(ci_code),
      .ci_valid(ci_valid), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_be    = be;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic push(input int p, input logic [3:0] code);
      exp_q.push_back({p[3:0], code});
   endtask

   task automatic frame();
      @(negedge clk);
      frame_sync = 1'b1;
      @(negedge clk);
      frame_sync = 1'b0;
      #1 chk("R4 expected slot missing", 32'(exp_q.size()), 32'd0);
   endtask

   // monitor: pop one expected item for every valid slot seen
   always @(negedge clk) begin
      if (rst_n) begin
         for (int p = 0; p < 4; p++) begin
            if (ci_valid[p]) begin
               if (exp_q.size() == 0) begin
                  chk("R4 unexpected slot (R7/R9)", {24'd0, p[3:0], ci_code[p*4 +: 4]}, 32'hFFFF_FFFF);
               end else begin
                  chk("R4 slot value", {24'd0, p[3:0], ci_code[p*4 +: 4]}, {24'd0, exp_q.pop_front()});
               end
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, d); chk("R1 code reg", d, 32'h0);
      rd(2'd1, d); chk("R1 status reg", d, 32'h0);
      rd(2'd2, d); chk("R1 mask reg", d, 32'h0);
      chk("R1 outputs", {ci_code, ci_valid, irq}, 32'h0);

      // R2 lane mapping and reserved bits, port 0 starts with code F
      wr(2'd0, 32'hFFFF_FFFF, 4'b1000);
      rd(2'd0, d); chk("R2 port0 lane", d, 32'h1F00_0000);
      wr(2'd2, 32'h1, 4'hF);
      push(0, 4'hF); frame();
      rd(2'd1, d); chk("R5 no ack after one frame", d, 32'h0);
      push(0, 4'hF); frame();
      rd(2'd1, d); chk("R5 ack after two frames", d, 32'h1);
      rd(2'd0, d); chk("R6 ready cleared, code kept", d, 32'h0F00_0000);
      chk("R11 irq enabled", {31'd0, irq}, 32'h1);

      // R7 idle port repeats last acknowledged code
      frame();
      chk("R7 idle slot code", {28'd0, ci_code[3:0]}, 32'hF);

      // R10 write-one-to-clear
      wr(2'd1, 32'h2, 4'hF);
      rd(2'd1, d); chk("R10 write one to other bit", d, 32'h1);
      wr(2'd1, 32'h1, 4'hF);
      rd(2'd1, d); chk("R10 cleared", d, 32'h0);
      chk("R11 irq after clear", {31'd0, irq}, 32'h0);

      // R3 level high does not retrigger (port 2, lane 1)
      wr(2'd0, 32'h0000_1500, 4'b0010);
      push(2, 4'h5); frame();
      wr(2'd0, 32'h0000_1500, 4'b0010);
      push(2, 4'h5); frame();
      rd(2'd1, d); chk("R3 no restart on same write", d, 32'h4);
      chk("R11 masked port", {31'd0, irq}, 32'h0);
      wr(2'd2, 32'h4, 4'hF);
      chk("R11 unmasked port", {31'd0, irq}, 32'h1);
      wr(2'd1, 32'h4, 4'hF);

      // R8 code change restarts count (port 1, lane 2)
      wr(2'd0, 32'h0013_0000, 4'b0100);
      push(1, 4'h3); frame();
      wr(2'd0, 32'h0017_0000, 4'b0100);
      push(1, 4'h7); frame();
      rd(2'd1, d); chk("R8 no ack after restart frame", d, 32'h0);
      push(1, 4'h7); frame();
      rd(2'd1, d); chk("R8 ack after two new frames", d, 32'h2);
      wr(2'd1, 32'h2, 4'hF);

      // R9 abort by clearing ready (port 3, lane 0)
      wr(2'd0, 32'h0000_0019, 4'b0001);
      push(3, 4'h9); frame();
      wr(2'd0, 32'h0000_0009, 4'b0001);
      frame();
      rd(2'd1, d); chk("R9 no ack after abort", d, 32'h0);
      chk("R7 slot after abort", {28'd0, ci_code[15:12]}, 32'h0);

      // two ports together
      wr(2'd0, 32'h1A00_001C, 4'b1001);
      push(0, 4'hA); push(3, 4'hC); frame();
      push(0, 4'hA); push(3, 4'hC); frame();
      rd(2'd1, d); chk("R5 two ports acked", d, 32'h9);
      rd(2'd0, d); chk("R6 both ready cleared", d, 32'h0A07_050C);

      // R13 unused select
      wr(2'd3, 32'hFFFF_FFFF, 4'hF);
      rd(2'd3, d); chk("R13 unused reads zero", d, 32'h0);
      rd(2'd0, d); chk("R13 write ignored", d, 32'h0A07_050C);

      // R12 software reset mid-transmission
      wr(2'd0, 32'h0016_0000, 4'b0100);
      push(1, 4'h6); frame();
      @(negedge clk); sw_rst = 1'b1;
      @(negedge clk); sw_rst = 1'b0;
      rd(2'd0, d); chk("R12 code reg", d, 32'h0);
      rd(2'd1, d); chk("R12 status reg", d, 32'h0);
      rd(2'd2, d); chk("R12 mask reg", d, 32'h0);
      chk("R12 outputs", {ci_code, ci_valid, irq}, 32'h0);
      frame();
      chk("R12 idle after reset", {16'd0, ci_code}, 32'h0);

      chk("R4 queue drained", 32'(exp_q.size()), 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule